// File: doc/BRIEF.md
# Receive Descriptor/Data Phase Sink

This block sits on the application side of a PCI Express transaction-layer receive port. That port delivers each request in two phases. In the descriptor phase, a one-cycle request strobe comes with a 136-bit descriptor. In the optional data phase, 64-bit beats arrive under a framing signal. The sink captures the descriptor and turns its top byte into a 3-bit base-address-region index with a hit flag and an error flag. It then follows the framing signal and forwards each data beat onto a plain output stream marked with first and last flags.

No length counter is used. The framing input drops one cycle ahead of the final beat, so the first valid beat seen with framing low inside an open phase is the last one.

Non-posted requests are counted in a small occupancy tracker. When the tracker fills, the block raises a retry and mask pair. Non-posted requests are then turned away, while posted requests and completions keep flowing. A downstream consumer frees slots with a pop strobe. One instance serves one virtual channel; a two-channel port uses two instances.

Top module: `rxdp_sink`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is low, including the region index, and the captured descriptor is zero.
- R2: An accepted request (strobe high and not a refused non-posted request) gives a one-cycle `desc_vld_o` on the next cycle. `desc_o` holds that descriptor until the next accepted request.
- R3: With the capture, `bar_idx_o` gives the position of the lowest set bit among descriptor bits 128 to 134, with `bar_hit_o` high. Values 0 to 5 name base regions 0 to 5 and 6 names the expansion ROM. If none of those bits is set, `bar_hit_o` is low and `bar_idx_o` is 7. Both hold until the next accepted request.
- R4: `err_bar_o` is high together with `desc_vld_o` when more than one of bits 128 to 134 is set, or when bit 135 is set.
- R5: A beat is taken when `dv_i` is high and either `dfr_i` is high or a phase is open. A phase opens on any cycle with `dfr_i` high. A taken beat appears one cycle later on `st_valid_o`, with `st_data_o` equal to `data_i`.
- R6: `st_first_o` marks the first beat taken in a phase. `st_last_o` marks a beat taken with `dfr_i` low. That beat closes the phase, so the phase length needs no count, and a single-beat phase carries both flags.
- R7: A `dv_i` beat with `dfr_i` low and no open phase is dropped and pulses `err_orphan_o` on the next cycle.
- R8: A request strobe that arrives while a phase is open, other than on the cycle its final beat is taken, pulses `err_overlap_o` on the next cycle.
- R9: Each accepted non-posted request (`req_np_i` high) adds one to the occupancy. `np_pop_i` takes one away and is ignored at zero. `retry_o` and `mask_o` are both high exactly while the occupancy equals `NP_DEPTH`.
- R10: A non-posted request made while `retry_o` is high is refused. It gives no `desc_vld_o` and leaves `desc_o` and the occupancy unchanged. Requests with `req_np_i` low are still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Descriptor-phase request strobe |
| req_np_i | input | 1 | Request is non-posted |
| desc_i | input | DESC_W | Descriptor; top byte is the region-hit field |
| dfr_i | input | 1 | Data-phase framing |
| dv_i | input | 1 | Data beat valid |
| data_i | input | DATA_W | Data beat |
| np_pop_i | input | 1 | Release one non-posted slot |
| desc_vld_o | output | 1 | Descriptor captured this cycle |
| desc_o | output | DESC_W | Captured descriptor |
| bar_idx_o | output | 3 | Encoded region index, 7 when none |
| bar_hit_o | output | 1 | A region bit was set |
| err_bar_o | output | 1 | Region field malformed |
| st_valid_o | output | 1 | Stream beat valid |
| st_data_o | output | DATA_W | Stream data |
| st_first_o | output | 1 | First beat of a phase |
| st_last_o | output | 1 | Final beat of a phase |
| err_orphan_o | output | 1 | Beat outside any phase |
| err_overlap_o | output | 1 | Request while a phase is open |
| retry_o | output | 1 | Non-posted requests must be retried |
| mask_o | output | 1 | Non-posted requests masked |

## Verification
The hardest case to reach is the end of a phase. The final beat is known only from the framing input having already fallen, so it depends on how `dfr_i` and `dv_i` gaps interleave. The stimulus covers phases that open with and without a beat on the opening cycle, idle cycles both before and after framing drops, and single-beat phases. It also covers a new request landing exactly on the final-beat cycle. A long run of random framing, valid, request and pop activity follows, compared against the bench model each cycle. That run drives the occupancy tracker through repeated fill, refusal and drain.

// File: rtl/rxdp_pkg.sv
package rxdp_pkg;
   localparam int BAR_FLD_W = 8;
   localparam int BAR_SLOTS = 7;
   localparam logic [2:0] NO_HIT_IDX = 3'd7;

   typedef logic [2:0] bar_idx_t;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_OPEN = 1'b1
   } phase_e;
endpackage

// File: rtl/rxdp_bar_dec.sv
module rxdp_bar_dec
   import rxdp_pkg::*;
(
   input  logic [BAR_FLD_W-1:0] fld_i,
   output bar_idx_t             idx_o,
   output logic                 hit_o,
   output logic                 bad_o
);
   logic [BAR_SLOTS-1:0] low_hot;

   for (genvar g = 0; g < BAR_SLOTS; g++) begin : g_slot
      if (g == 0) begin : g_first
         assign low_hot[g] = fld_i[g];
      end else begin : g_rest
         assign low_hot[g] = fld_i[g] & ~(|fld_i[g-1:0]);
      end
   end

   always_comb begin
      idx_o = NO_HIT_IDX;
      for (int s = 0; s < BAR_SLOTS; s++) begin
         if (low_hot[s]) idx_o = bar_idx_t'(s);
      end
   end

   assign hit_o = |fld_i[BAR_SLOTS-1:0];
   assign bad_o = ($countones(fld_i[BAR_SLOTS-1:0]) > 1) | fld_i[BAR_FLD_W-1];
endmodule

// File: rtl/rxdp_phase_trk.sv
module rxdp_phase_trk
   import rxdp_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              dfr_i,
   input  logic              dv_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              st_valid_o,
   output logic [DATA_W-1:0] st_data_o,
   output logic              st_first_o,
   output logic              st_last_o,
   output logic              err_orphan_o,
   output logic              err_overlap_o
);
   phase_e ph_q, ph_d;
   logic   seen_q, seen_d;
   logic   beat, fin, first, orphan, overlap;

   assign beat    = dv_i & (dfr_i | (ph_q == PH_OPEN));
   assign fin     = beat & ~dfr_i;
   assign first   = beat & ~seen_q;
   assign orphan  = dv_i & ~dfr_i & (ph_q == PH_IDLE);
   assign overlap = req_i & (ph_q == PH_OPEN) & ~fin;

   always_comb begin
      ph_d   = ph_q;
      seen_d = seen_q;
      if (dfr_i)      ph_d = PH_OPEN;
      else if (fin)   ph_d = PH_IDLE;
      if (fin)        seen_d = 1'b0;
      else if (beat)  seen_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q          <= PH_IDLE;
         seen_q        <= 1'b0;
         err_orphan_o  <= 1'b0;
         err_overlap_o <= 1'b0;
      end else begin
         ph_q          <= ph_d;
         seen_q        <= seen_d;
         err_orphan_o  <= orphan;
         err_overlap_o <= overlap;
      end
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_valid_o <= 1'b0;
            st_first_o <= 1'b0;
            st_last_o  <= 1'b0;
            st_data_o  <= '0;
         end else begin
            st_valid_o <= beat;
            st_first_o <= first;
            st_last_o  <= fin;
            if (beat) st_data_o <= data_i;
         end
      end
   end else begin : g_comb_out
      assign st_valid_o = beat;
      assign st_first_o = first;
      assign st_last_o  = fin;
      assign st_data_o  = data_i;
   end
endmodule

// File: rtl/rxdp_np_gate.sv
module rxdp_np_gate #(
   parameter int NP_DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic req_np_i,
   input  logic np_pop_i,
   output logic accept_o,
   output logic retry_o,
   output logic mask_o
);
   localparam int CNT_W = $clog2(NP_DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(NP_DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             full, push, pop;

   assign full     = (cnt_q == FULL_LVL);
   assign accept_o = req_i & ~(req_np_i & full);
   assign push     = accept_o & req_np_i;
   assign pop      = np_pop_i & (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (push & ~pop) cnt_q <= cnt_q + 1'b1;
      else if (pop & ~push) cnt_q <= cnt_q - 1'b1;
   end

   assign retry_o = full;
   assign mask_o  = full;
endmodule

// File: rtl/rxdp_sink.sv
module rxdp_sink
   import rxdp_pkg::*;
#(
   parameter int DESC_W   = 136,
   parameter int DATA_W   = 64,
   parameter int NP_DEPTH = 4,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_np_i,
   input  logic [DESC_W-1:0] desc_i,
   input  logic              dfr_i,
   input  logic              dv_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              np_pop_i,
   output logic              desc_vld_o,
   output logic [DESC_W-1:0] desc_o,
   output logic [2:0]        bar_idx_o,
   output logic              bar_hit_o,
   output logic              err_bar_o,
   output logic              st_valid_o,
   output logic [DATA_W-1:0] st_data_o,
   output logic              st_first_o,
   output logic              st_last_o,
   output logic              err_orphan_o,
   output logic              err_overlap_o,
   output logic              retry_o,
   output logic              mask_o
);
   localparam int BAR_LSB = DESC_W - BAR_FLD_W;

   if (DESC_W < 2 * BAR_FLD_W) begin : g_chk_desc
      $error("rxdp_sink: DESC_W too small for the region field");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("rxdp_sink: DATA_W must be positive");
   end
   if (NP_DEPTH < 1) begin : g_chk_depth
      $error("rxdp_sink: NP_DEPTH must be at least 1");
   end

   logic     accept, hit, bad;
   bar_idx_t idx;

   rxdp_np_gate #(.NP_DEPTH(NP_DEPTH)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .req_np_i (req_np_i),
      .np_pop_i (np_pop_i),
      .accept_o (accept),
      .retry_o  (retry_o),
      .mask_o   (mask_o)
   );

   rxdp_bar_dec u_dec (
      .fld_i (desc_i[DESC_W-1:BAR_LSB]),
      .idx_o (idx),
      .hit_o (hit),
      .bad_o (bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_vld_o <= 1'b0;
         desc_o     <= '0;
         bar_idx_o  <= '0;
         bar_hit_o  <= 1'b0;
         err_bar_o  <= 1'b0;
      end else begin
         desc_vld_o <= accept;
         err_bar_o  <= accept & bad;
         if (accept) begin
            desc_o    <= desc_i;
            bar_idx_o <= idx;
            bar_hit_o <= hit;
         end
      end
   end

   rxdp_phase_trk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_trk (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req_i),
      .dfr_i         (dfr_i),
      .dv_i          (dv_i),
      .data_i        (data_i),
      .st_valid_o    (st_valid_o),
      .st_data_o     (st_data_o),
      .st_first_o    (st_first_o),
      .st_last_o     (st_last_o),
      .err_orphan_o  (err_orphan_o),
      .err_overlap_o (err_overlap_o)
   );
endmodule

// File: rtl/rxdp_sink_chk.sv
module rxdp_sink_chk #(
   parameter int DESC_W   = 136,
   parameter int NP_DEPTH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              req_np_i,
   input logic              dfr_i,
   input logic              dv_i,
   input logic              np_pop_i,
   input logic              desc_vld_o,
   input logic [DESC_W-1:0] desc_o,
   input logic [2:0]        bar_idx_o,
   input logic              bar_hit_o,
   input logic              err_bar_o,
   input logic              err_orphan_o,
   input logic              err_overlap_o,
   input logic              retry_o
);
   localparam int BAR_LSB = DESC_W - 8;

   int occ;
   always_ff @(posedge clk) begin
      if (!rst_n) occ <= 0;
      else occ <= occ + ((req_i && req_np_i && !retry_o) ? 1 : 0)
                      - ((np_pop_i && occ > 0) ? 1 : 0);
   end

   // R2
   a_r2_vld_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      desc_vld_o |-> $past(req_i));
   // R3
   a_r3_idx_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_vld_o && bar_hit_o) |-> desc_o[BAR_LSB + int'(bar_idx_o)]);
   // R3
   a_r3_no_hit_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_vld_o && !bar_hit_o) |-> (bar_idx_o == 3'd7));
   // R4
   a_r4_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_vld_o && desc_o[DESC_W-1]) |-> err_bar_o);
   // R7
   a_r7_orphan_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_orphan_o |-> $past(dv_i && !dfr_i));
   // R8
   a_r8_overlap_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_overlap_o |-> $past(req_i));
   // R9
   a_r9_full_level: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o == (occ == NP_DEPTH));
   // R10
   a_r10_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && req_np_i && retry_o) |=> !desc_vld_o);
endmodule

bind rxdp_sink rxdp_sink_chk #(.DESC_W(DESC_W), .NP_DEPTH(NP_DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_i         (req_i),
   .req_np_i      (req_np_i),
   .dfr_i         (dfr_i),
   .dv_i          (dv_i),
   .np_pop_i      (np_pop_i),
   .desc_vld_o    (desc_vld_o),
   .desc_o        (desc_o),
   .bar_idx_o     (bar_idx_o),
   .bar_hit_o     (bar_hit_o),
   .err_bar_o     (err_bar_o),
   .err_orphan_o  (err_orphan_o),
   .err_overlap_o (err_overlap_o),
   .retry_o       (retry_o)
);

// File: tb/tb_rxdp_sink.sv
module tb_rxdp_sink;
   localparam int DESC_W = 136;
   localparam int DATA_W = 64;
   localparam int DEPTH  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0, req_np_i = 1'b0, dfr_i = 1'b0, dv_i = 1'b0, np_pop_i = 1'b0;
   logic [DESC_W-1:0] desc_i = '0;
   logic [DATA_W-1:0] data_i = '0;

   logic desc_vld_o, bar_hit_o, err_bar_o, st_valid_o, st_first_o, st_last_o;
   logic err_orphan_o, err_overlap_o, retry_o, mask_o;
   logic [DESC_W-1:0] desc_o;
   logic [DATA_W-1:0] st_data_o;
   logic [2:0] bar_idx_o;

   always #5 clk = ~clk;

   rxdp_sink #(.DESC_W(DESC_W), .DATA_W(DATA_W), .NP_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_np_i(req_np_i),
      .desc_i(desc_i), .dfr_i(dfr_i), .dv_i(dv_i), .data_i(data_i),
      .np_pop_i(np_pop_i), .desc_vld_o(desc_vld_o), .desc_o(desc_o),
      .bar_idx_o(bar_idx_o), .bar_hit_o(bar_hit_o), .err_bar_o(err_bar_o),
      .st_valid_o(st_valid_o), .st_data_o(st_data_o), .st_first_o(st_first_o),
      .st_last_o(st_last_o), .err_orphan_o(err_orphan_o),
      .err_overlap_o(err_overlap_o), .retry_o(retry_o), .mask_o(mask_o));

   int n_checks = 0;
   int n_fail   = 0;

   // ---------------- behavioural reference ----------------
   int occ;
   bit m_open;
   int m_beats;
   logic e_vld, e_hit, e_bad, e_sv, e_first, e_last, e_orph, e_ovl;
   logic [2:0] e_idx;
   logic [DESC_W-1:0] e_desc;
   logic [DATA_W-1:0] e_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         occ = 0; m_open = 0; m_beats = 0;
         e_vld <= 0; e_hit <= 0; e_bad <= 0; e_sv <= 0; e_first <= 0;
         e_last <= 0; e_orph <= 0; e_ovl <= 0; e_idx <= 0; e_desc <= '0; e_data <= '0;
      end else begin
         bit acc, beat, fin;
         int ones, lo;
         acc  = req_i && !(req_np_i && occ == DEPTH);
         e_vld <= acc;
         ones = 0; lo = 7;
         for (int b = 6; b >= 0; b--) if (desc_i[128+b]) begin ones++; lo = b; end
         e_bad <= acc && (ones > 1 || desc_i[135]);
         if (acc) begin e_desc <= desc_i; e_idx <= 3'(lo); e_hit <= (ones > 0); end
         occ = occ + ((acc && req_np_i) ? 1 : 0) - ((np_pop_i && occ > 0) ? 1 : 0);
         beat = dv_i && (dfr_i || m_open);
         fin  = beat && !dfr_i;
         e_sv <= beat; e_first <= beat && m_beats == 0; e_last <= fin;
         if (beat) e_data <= data_i;
         e_orph <= dv_i && !dfr_i && !m_open;
         e_ovl  <= req_i && m_open && !fin;
         if (fin) begin m_open = 0; m_beats = 0; end
         else begin
            if (dfr_i) m_open = 1;
            if (beat) m_beats++;
         end
      end
   end

   task automatic chk(input string tag, input logic [DESC_W-1:0] act, input logic [DESC_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 desc_vld", DESC_W'(desc_vld_o), DESC_W'(e_vld));
      chk("R2 desc", desc_o, e_desc);
      chk("R3 idx", DESC_W'(bar_idx_o), DESC_W'(e_idx));
      chk("R3 hit", DESC_W'(bar_hit_o), DESC_W'(e_hit));
      chk("R4 err_bar", DESC_W'(err_bar_o), DESC_W'(e_bad));
      chk("R5 st_valid", DESC_W'(st_valid_o), DESC_W'(e_sv));
      if (e_sv) begin
         chk("R5 st_data", DESC_W'(st_data_o), DESC_W'(e_data));
         chk("R6 first", DESC_W'(st_first_o), DESC_W'(e_first));
         chk("R6 last", DESC_W'(st_last_o), DESC_W'(e_last));
      end
      chk("R7 orphan", DESC_W'(err_orphan_o), DESC_W'(e_orph));
      chk("R8 overlap", DESC_W'(err_overlap_o), DESC_W'(e_ovl));
      chk("R9 retry", DESC_W'(retry_o), DESC_W'(occ == DEPTH));
      chk("R9 mask", DESC_W'(mask_o), DESC_W'(occ == DEPTH));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic cyc(input logic r, input logic np, input logic [7:0] fld,
                      input logic fr, input logic v, input logic [63:0] dat, input logic pop);
      req_i = r; req_np_i = np; desc_i = {fld, 128'(dat ^ 64'h5A5A)};
      dfr_i = fr; dv_i = v; data_i = dat; np_pop_i = pop;
      tick();
   endtask

   task automatic idle(); cyc(0, 0, 8'h00, 0, 0, 64'h0, 0); endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [DESC_W-1:0] saved;
      @(negedge clk);
      repeat (3) tick();
      // R1: outputs low during reset
      chk("R1 reset outs", DESC_W'({desc_vld_o, bar_hit_o, err_bar_o, st_valid_o,
          err_orphan_o, err_overlap_o, retry_o, mask_o, bar_idx_o}), '0);
      chk("R1 reset desc", desc_o, '0);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset", DESC_W'({desc_vld_o, st_valid_o, retry_o, mask_o}), '0);

      // R3 / R4: region decoding cases
      cyc(1, 0, 8'h04, 0, 0, 64'h11, 0);   // region 2
      chk("R3 idx region2", DESC_W'(bar_idx_o), DESC_W'(3'd2));
      cyc(1, 0, 8'h40, 0, 0, 64'h12, 0);   // expansion ROM
      chk("R3 idx rom", DESC_W'(bar_idx_o), DESC_W'(3'd6));
      cyc(1, 0, 8'h00, 0, 0, 64'h13, 0);   // none
      chk("R3 idx none", DESC_W'({bar_hit_o, bar_idx_o}), DESC_W'(4'b0111));
      cyc(1, 0, 8'h0A, 0, 0, 64'h14, 0);   // two bits
      chk("R4 multi", DESC_W'({err_bar_o, bar_idx_o}), DESC_W'(4'b1001));
      cyc(1, 0, 8'h81, 0, 0, 64'h15, 0);   // reserved bit
      chk("R4 reserved", DESC_W'(err_bar_o), DESC_W'(1));
      idle();

      // R5 / R6: framing with request, beats with gaps
      cyc(1, 0, 8'h01, 1, 1, 64'hA0, 0);
      chk("R6 first beat", DESC_W'({st_valid_o, st_first_o, st_last_o}), DESC_W'(3'b110));
      cyc(0, 0, 8'h00, 1, 0, 64'hA1, 0);
      cyc(0, 0, 8'h00, 1, 1, 64'hA2, 0);
      cyc(0, 0, 8'h00, 0, 0, 64'hA3, 0);
      cyc(0, 0, 8'h00, 0, 1, 64'hA4, 0);
      chk("R6 last beat", DESC_W'({st_valid_o, st_last_o}), DESC_W'(2'b11));
      chk("R5 last data", DESC_W'(st_data_o), DESC_W'(64'hA4));
      idle();
      // single-beat phase, framing one cycle late
      cyc(1, 0, 8'h02, 0, 0, 64'h0, 0);
      cyc(0, 0, 8'h00, 1, 0, 64'h0, 0);
      cyc(0, 0, 8'h00, 0, 1, 64'hB0, 0);
      chk("R6 single", DESC_W'({st_first_o, st_last_o}), DESC_W'(2'b11));
      // R7: orphan beat
      cyc(0, 0, 8'h00, 0, 1, 64'hC0, 0);
      chk("R7 orphan drop", DESC_W'({st_valid_o, err_orphan_o}), DESC_W'(2'b01));
      // R8: overlap, then request on final-beat cycle
      cyc(1, 0, 8'h01, 1, 0, 64'h0, 0);
      cyc(1, 0, 8'h02, 0, 0, 64'h0, 0);
      chk("R8 overlap", DESC_W'(err_overlap_o), DESC_W'(1));
      cyc(1, 0, 8'h04, 0, 1, 64'hD0, 0);
      chk("R8 final cycle ok", DESC_W'(err_overlap_o), DESC_W'(0));
      idle();

      // R9 / R10: fill the non-posted tracker
      for (int i = 0; i < DEPTH; i++) cyc(1, 1, 8'h01, 0, 0, 64'(i), 0);
      chk("R9 full", DESC_W'({retry_o, mask_o}), DESC_W'(2'b11));
      saved = desc_o;
      cyc(1, 1, 8'h08, 0, 0, 64'hEE, 0);
      chk("R10 refused", DESC_W'(desc_vld_o), DESC_W'(0));
      chk("R10 desc kept", desc_o, saved);
      cyc(1, 0, 8'h10, 0, 0, 64'hEF, 0);
      chk("R10 posted passes", DESC_W'(desc_vld_o), DESC_W'(1));
      cyc(0, 0, 8'h00, 0, 0, 64'h0, 1);
      chk("R9 drained", DESC_W'({retry_o, mask_o}), DESC_W'(0));
      for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 8'h00, 0, 0, 64'h0, 1);
      chk("R9 pop at zero", DESC_W'(retry_o), DESC_W'(0));

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] f;
         f = 8'(1 << ($urandom % 8));
         if (($urandom % 8) == 0) f = 8'($urandom);
         cyc(($urandom % 4) == 0, $urandom % 2, f, ($urandom % 3) == 0,
             ($urandom % 2) == 1, {$urandom, $urandom}, ($urandom % 5) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule